// File: doc/BRIEF.md
# Timer Event Output Pin Generator

This block drives one registered output pin from the event strobes of a timer counter. The counter core delivers a one-cycle overflow strobe and a one-cycle compare-match strobe, a run flag, a compare-enable flag and its control word. A two-bit field in the control word selects which strobes act on the pin. A mode bit picks between two shapes. In pulse mode each selected event inverts the pin away from its idle level for a single clock. In toggle mode each selected event flips the pin, so a pair of events gives one period of a PWM wave.

A programmable idle level sets the pin while the counter is stopped, and it is also the level from which a run begins. A separate control bit takes the pin away from the timer and drives it straight from the idle-level bit, so the pin acts as a plain general-purpose output. The counter and the register bus sit outside this block. Every change reaches the pin one clock after the inputs that cause it.

Top module: `tpo_out_gen`

## Requirements
- R1: While reset is asserted the pin reads 0, which is the RESET_LVL default.
- R2: While the run flag is low and bit 14 is low, the pin takes the value of control bit 7 (the idle level) on the next clock, including right after bit 7 is rewritten.
- R3: While control bit 14 is 1, the pin follows control bit 7 on the next clock, whatever the run flag and the strobes do.
- R4: Control bits 11:10 select the events. 0 selects none, 1 selects overflow only and 2 selects overflow or compare. Value 3 is reserved and selects none, so with 0 or 3 the pin stays at the idle level in pulse mode and holds in toggle mode.
- R5: A compare strobe counts as an event only while the compare-enable input is 1.
- R6: In pulse mode (bit 12 = 0) while running, the pin is the inverse of bit 7 for exactly the one clock after each cycle that carries a selected event, and equals bit 7 otherwise.
- R7: In toggle mode (bit 12 = 1) while running, the pin inverts on the clock after each selected event and holds its level between events.
- R8: In toggle mode, an overflow and an enabled compare in the same cycle with field value 2 invert the pin once, not twice.
- R9: When the run flag rises, the pin starts from the idle level and stays there until the first selected event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter running flag |
| cmp_en_i | input | 1 | Compare enable from the timer control |
| ovf_stb_i | input | 1 | One-cycle overflow strobe |
| cmp_stb_i | input | 1 | One-cycle compare-match strobe |
| ctrl_i | input | CTRL_W | Control word: bit 7 idle level, bits 11:10 event select, bit 12 toggle mode, bit 14 general-purpose output |
| pin_o | output | 1 | Registered output pin |

## Verification
The hardest case to reach from the ports is a toggle-mode cycle with field value 2 in which an overflow and an enabled compare land together. That cycle must be told apart from two separate events, which it can only be if the pin state before it is known. A directed phase builds the case on purpose: it puts the pin at a known level, applies both strobes at once and checks for a single inversion. It then repeats the same stimulus with compare enable low and with field value 1. A long seeded random phase then mixes run changes, mode changes and strobes while a behavioural model predicts the pin on every clock, and it reaches coincident events and restarts from many different prior states.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_OVF  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_e;

  localparam int unsigned IDLE_BIT   = 7;
  localparam int unsigned TRIG_LSB   = 10;
  localparam int unsigned TOGGLE_BIT = 12;
  localparam int unsigned GPO_BIT    = 14;
  localparam int unsigned MIN_CTRL_W = GPO_BIT + 1;

  typedef struct packed {
    logic  gpo;
    logic  toggle;
    trig_e trig;
    logic  idle_lvl;
  } pin_cfg_t;

  // Event qualification: which strobes count for the chosen field value.
  function automatic logic qualify_evt(input trig_e trig, input logic ovf,
                                       input logic cmp, input logic cmp_en);
    logic cmp_ok;
    cmp_ok = cmp & cmp_en;
    case (trig)
      TRIG_OVF:  qualify_evt = ovf;
      TRIG_BOTH: qualify_evt = ovf | cmp_ok;
      default:   qualify_evt = 1'b0;
    endcase
  endfunction

  // Next pin level from configuration, run state, event and current level.
  function automatic logic next_level(input pin_cfg_t cfg, input logic run,
                                      input logic evt, input logic cur);
    if (cfg.gpo || !run) next_level = cfg.idle_lvl;
    else if (cfg.toggle) next_level = cur ^ evt;
    else                 next_level = cfg.idle_lvl ^ evt;
  endfunction

endpackage

// File: rtl/tpo_cfg_decode.sv
module tpo_cfg_decode
  import tpo_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output pin_cfg_t          cfg_o
);

  localparam int unsigned TRIG_MSB = TRIG_LSB + 1;

  logic unused_ctrl_bits;

  assign cfg_o.gpo      = ctrl_i[GPO_BIT];
  assign cfg_o.toggle   = ctrl_i[TOGGLE_BIT];
  assign cfg_o.trig     = trig_e'(ctrl_i[TRIG_MSB:TRIG_LSB]);
  assign cfg_o.idle_lvl = ctrl_i[IDLE_BIT];
  assign unused_ctrl_bits = ^ctrl_i;

endmodule

// File: rtl/tpo_evt_qual.sv
module tpo_evt_qual
  import tpo_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  trig_e trig_i,
  input  logic  ovf_stb_i,
  input  logic  cmp_stb_i,
  input  logic  cmp_en_i,
  output logic  evt_o,
  output logic  both_o
);

  assign evt_o  = qualify_evt(trig_i, ovf_stb_i, cmp_stb_i, cmp_en_i);
  assign both_o = (trig_i == TRIG_BOTH) & ovf_stb_i & cmp_stb_i & cmp_en_i;

  AST_CMP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_en_i && !ovf_stb_i) |-> !evt_o); // R5

  AST_FIELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == TRIG_OFF || trig_i == TRIG_RSVD) |-> !evt_o); // R4

endmodule

// File: rtl/tpo_level_next.sv
module tpo_level_next
  import tpo_pkg::*;
(
  input  pin_cfg_t cfg_i,
  input  logic     run_i,
  input  logic     evt_i,
  input  logic     cur_i,
  output logic     nxt_o
);

  assign nxt_o = next_level(cfg_i, run_i, evt_i, cur_i);

endmodule

// File: rtl/tpo_out_gen.sv
module tpo_out_gen
  import tpo_pkg::*;
#(
  parameter int unsigned CTRL_W    = 16,
  parameter bit          RESET_LVL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cmp_en_i,
  input  logic              ovf_stb_i,
  input  logic              cmp_stb_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              pin_o
);

  pin_cfg_t cfg;
  logic     evt_sel;
  logic     evt_both;
  logic     pin_nxt;
  logic     pin_q;

  initial begin
    if (CTRL_W < MIN_CTRL_W) $error("CTRL_W too small for control fields");
  end

  tpo_cfg_decode #(.CTRL_W(CTRL_W)) u_dec (
    .ctrl_i (ctrl_i),
    .cfg_o  (cfg)
  );

  tpo_evt_qual u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (cfg.trig),
    .ovf_stb_i (ovf_stb_i),
    .cmp_stb_i (cmp_stb_i),
    .cmp_en_i  (cmp_en_i),
    .evt_o     (evt_sel),
    .both_o    (evt_both)
  );

  tpo_level_next u_next (
    .cfg_i (cfg),
    .run_i (run_i),
    .evt_i (evt_sel),
    .cur_i (pin_q),
    .nxt_o (pin_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= RESET_LVL;
    else         pin_q <= pin_nxt;
  end

  assign pin_o = pin_q;

  AST_RESET_LVL: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == RESET_LVL)); // R1

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pin_o == $past(ctrl_i[IDLE_BIT]))); // R2

  AST_GPO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[GPO_BIT] |=> (pin_o == $past(ctrl_i[IDLE_BIT]))); // R3

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cfg.gpo && !cfg.toggle && evt_sel)
      |=> (pin_o != $past(ctrl_i[IDLE_BIT]))); // R6

  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cfg.gpo && cfg.toggle && evt_sel) |=> (pin_o != $past(pin_o))); // R7

  AST_TOGGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cfg.gpo && cfg.toggle && !evt_sel) |=> $stable(pin_o)); // R7

  AST_BOTH_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cfg.gpo && cfg.toggle && evt_both) |=> (pin_o != $past(pin_o))); // R8

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ctrl_i[GPO_BIT] && !evt_sel && !$past(run_i) && !$past(ctrl_i[GPO_BIT])
      && (ctrl_i[IDLE_BIT] == $past(ctrl_i[IDLE_BIT])))
      |=> (pin_o == $past(ctrl_i[IDLE_BIT]))); // R9

endmodule

// File: tb/tpo_out_gen_tb_top.sv
module tpo_out_gen_tb_top;

  localparam int CTRL_W = 16;
  localparam int WATCHDOG_CYC = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run = 1'b0;
  logic              cen = 1'b0;
  logic              ovf = 1'b0;
  logic              cmp = 1'b0;
  logic [CTRL_W-1:0] ctrl = '0;
  logic              pin;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    exp_pin = 1'b0;
  bit    prev_run = 1'b0;
  bit    checking = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  tpo_out_gen #(.CTRL_W(CTRL_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .run_i     (run),
    .cmp_en_i  (cen),
    .ovf_stb_i (ovf),
    .cmp_stb_i (cmp),
    .ctrl_i    (ctrl),
    .pin_o     (pin)
  );

  // Behavioural reference: field positions bit7 idle, 11:10 select, 12 toggle, 14 gpo.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_pin  = 1'b0;
      prev_run = 1'b0;
      tag      = "R1";
    end else begin
      bit idle, tgl, gpo, hit;
      int sel;
      idle = ctrl[7];
      tgl  = ctrl[12];
      gpo  = ctrl[14];
      sel  = int'(ctrl[11:10]);
      hit  = 1'b0;
      if (sel == 1 && ovf) hit = 1'b1;
      if (sel == 2 && ovf) hit = 1'b1;
      if (sel == 2 && cmp && cen) hit = 1'b1;
      if (gpo) begin
        exp_pin = idle; tag = "R3";
      end else if (!run) begin
        exp_pin = idle; tag = "R2";
      end else begin
        if (tgl) exp_pin = exp_pin ^ hit;
        else     exp_pin = idle ^ hit;
        if (sel == 0 || sel == 3)                 tag = "R4";
        else if (tgl && sel == 2 && ovf && cmp && cen) tag = "R8";
        else if (cmp && !cen && !ovf)             tag = "R5";
        else if (!prev_run && !hit)               tag = "R9";
        else if (tgl)                             tag = "R7";
        else                                      tag = "R6";
      end
      prev_run = run && !gpo;
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      checks++;
      if (pin !== exp_pin) begin
        errors++;
        $display("FAIL %s: pin actual=%0b expected=%0b at %0t", tag, pin, exp_pin, $time);
      end
    end
  end

  task automatic drive(input bit r, input bit ce, input bit o, input bit c,
                       input bit idle, input bit [1:0] sel, input bit tgl, input bit gpo);
    @(negedge clk);
    run = r; cen = ce; ovf = o; cmp = c;
    ctrl = '0;
    ctrl[7] = idle; ctrl[11:10] = sel; ctrl[12] = tgl; ctrl[14] = gpo;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset value, checked while reset is held
    checking = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: stopped, idle level rewrites show up next clock
    drive(0, 0, 1, 1, 1, 2, 0, 0);
    drive(0, 0, 0, 0, 0, 2, 0, 0);
    drive(0, 1, 1, 1, 1, 1, 1, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0);

    // R3: gpo ignores run and strobes
    drive(1, 1, 1, 1, 0, 2, 1, 1);
    drive(1, 1, 1, 1, 1, 2, 1, 1);
    drive(1, 1, 1, 0, 1, 1, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 1);

    // R4/R6: pulse mode, each select value, with idle 0 and 1
    for (int idle = 0; idle < 2; idle++) begin
      for (int sel = 0; sel < 4; sel++) begin
        drive(0, 1, 0, 0, idle[0], 2'(sel), 0, 0);
        drive(1, 1, 0, 0, idle[0], 2'(sel), 0, 0);
        drive(1, 1, 1, 0, idle[0], 2'(sel), 0, 0);
        drive(1, 1, 0, 0, idle[0], 2'(sel), 0, 0);
        drive(1, 1, 0, 1, idle[0], 2'(sel), 0, 0);
        drive(1, 1, 0, 0, idle[0], 2'(sel), 0, 0);
        drive(1, 0, 0, 1, idle[0], 2'(sel), 0, 0); // R5
        drive(1, 0, 0, 0, idle[0], 2'(sel), 0, 0);
      end
    end

    // R7: toggle mode with overflow only, spaced events
    drive(0, 1, 0, 0, 0, 1, 1, 0);
    drive(1, 1, 0, 0, 0, 1, 1, 0); // R9 start
    for (int k = 0; k < 6; k++) begin
      drive(1, 1, 1, 0, 0, 1, 1, 0);
      drive(1, 1, 0, 1, 0, 1, 1, 0);
      drive(1, 1, 0, 0, 0, 1, 1, 0);
    end

    // R8: coincident events toggle once; then same with compare disabled / field 1
    drive(0, 1, 0, 0, 1, 2, 1, 0);
    drive(1, 1, 0, 0, 1, 2, 1, 0);
    for (int k = 0; k < 4; k++) begin
      drive(1, 1, 1, 1, 1, 2, 1, 0);
      drive(1, 1, 0, 0, 1, 2, 1, 0);
      drive(1, 0, 1, 1, 1, 2, 1, 0);
      drive(1, 1, 1, 1, 1, 1, 1, 0);
    end

    // R9: stop and restart resumes from idle level
    drive(0, 1, 0, 0, 0, 2, 1, 0);
    drive(1, 1, 0, 0, 0, 2, 1, 0);
    drive(1, 1, 1, 0, 0, 2, 1, 0);
    drive(0, 1, 0, 0, 1, 2, 1, 0);
    drive(1, 1, 0, 0, 1, 2, 1, 0);
    drive(1, 1, 0, 0, 1, 2, 1, 0);

    // Seeded random mix of everything
    void'($urandom(32'h5eed));
    for (int k = 0; k < 4000; k++) begin
      bit [31:0] r;
      r = $urandom();
      drive((r[3:0] != 0), r[4], (r[7:5] == 0), (r[10:8] == 0), r[11],
            r[13:12], r[14], (r[19:15] == 0));
    end

    drive(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule